// File: doc/BRIEF.md
# Vertically Doubled Bitmap Overlay Scanner

This block draws a stored monochrome bitmap into a composite video picture. A sync generator gives it a one-cycle line strobe at the end of each back porch, together with the number of the line that starts. The block folds the line number so that both interlaced fields fall into one range, tests the folded number against a vertical window, and on lines inside that window it fetches one bitmap row through a synchronous read port and shifts the bits out on a single pixel output, after a fixed delay from the strobe.

Every bitmap row is shown on two drawn lines in a row, so the image is stretched vertically by two. The row pointer is a word address that steps by the row width in words and returns to zero on its own once it passes the last image word. A pulse at the end of each vertical interval sets the pointer and the repeat flag back to their start values. Outside a drawn span the pixel output stays low, which shows as black.

Top module: `overlay_scanner`

## Requirements
- R1: A line number above FIELD_LINES (312) is reduced by FIELD_LINES before the window test. A line number at or below FIELD_LINES is tested as it is. For example, lines 431 and 119 draw alike.
- R2: A line is drawn only when its folded number is greater than WIN_START (118) and less than WIN_START + 2*IMG_H. A strobe for any other line leaves pix_o at 0 and issues no read. Such a strobe also cancels a line that is still being drawn.
- R3: On a drawn line, pix_o is 0 for START_CYC+1 cycles after the clock edge that samples line_strobe_i. The first pixel is then output from the next edge onwards.
- R4: Each bitmap row is drawn on two drawn lines in a row. The row pointer moves on only on every second drawn line. Strobes for lines that are not drawn leave the pointer and the flag unchanged.
- R5: The row pointer steps by WORDS words. When the next value would pass IMG_H*WORDS-1, the pointer becomes 0.
- R6: A drawn line outputs WORDS words read from addresses row_pointer+0 to row_pointer+WORDS-1, in increasing order. Each word is output MSB first, and each bit is held for PIX_DIV cycles, with no gap between words.
- R7: pix_o is 0 after the last pixel of a line and whenever no line is being drawn.
- R8: A high vblank_i sets the row pointer to 0 and clears the repeat flag. The next drawn line therefore shows row 0 and is then repeated once.
- R9: After reset, pix_o and rd_en_o are 0, the row pointer is 0 and the repeat flag is clear.
- R10: The read port returns rd_data_i in the cycle after the cycle in which rd_en_o is high. rd_addr_o is always below IMG_H*WORDS while rd_en_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_strobe_i | input | 1 | One-cycle pulse at the end of the back porch |
| line_num_i | input | LINE_W | Number of the line that starts, valid with the strobe |
| vblank_i | input | 1 | End-of-vertical-interval pulse |
| rd_en_o | output | 1 | Read request to the bitmap store |
| rd_addr_o | output | ADDR_W | Word address of the read |
| rd_data_i | input | WORD_W | Read data, valid the cycle after rd_en_o |
| pix_o | output | 1 | Pixel output, 1 = white |

## Verification
The clock edge that samples a line strobe is counted as edge zero. pix_o stays low through edge START_CYC. Pixel p of the line is present from edge START_CYC+1+p*PIX_DIV and stays for PIX_DIV cycles, and after that the output is low again. The driver pushes one expected pixel value for every cycle of a line into the scoreboard as it raises the strobe. The monitor compares one queue entry per cycle, 6 ns after each rising edge, so every expected value is matched to the exact cycle it is due in. Lines outside the window, wrap of the row pointer and vblank in the middle of the image all go through the same cycle-exact path.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_LOAD  = 2'd2,
    ST_SHIFT = 2'd3
  } ovl_state_e;
endpackage

// File: rtl/ovl_line_window.sv
module ovl_line_window #(
  parameter int LINE_W      = 10,
  parameter int FIELD_LINES = 312,
  parameter int WIN_START   = 118,
  parameter int IMG_H       = 48
) (
  input  logic [LINE_W-1:0] line_num_i,
  output logic              in_win_o
);
  localparam int WIN_END = WIN_START + 2 * IMG_H;

  logic [LINE_W-1:0] folded;

  always_comb begin
    if (line_num_i > LINE_W'(FIELD_LINES)) folded = line_num_i - LINE_W'(FIELD_LINES);
    else                                   folded = line_num_i;
    in_win_o = (folded > LINE_W'(WIN_START)) && (folded < LINE_W'(WIN_END));
  end
endmodule

// File: rtl/ovl_row_ptr.sv
module ovl_row_ptr #(
  parameter int IMG_H  = 48,
  parameter int WORDS  = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vblank_i,
  input  logic              adv_i,
  output logic [ADDR_W-1:0] row_base_o
);
  localparam int LAST_WORD = IMG_H * WORDS - 1;

  logic              rep_q;
  logic [ADDR_W:0]   nxt_sum;

  assign nxt_sum = {1'b0, row_base_o} + (ADDR_W+1)'(WORDS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_base_o <= '0;
      rep_q      <= 1'b0;
    end else if (vblank_i) begin
      row_base_o <= '0;
      rep_q      <= 1'b0;
    end else if (adv_i) begin
      if (rep_q) begin
        rep_q <= 1'b0;
        if (nxt_sum > (ADDR_W+1)'(LAST_WORD)) row_base_o <= '0;
        else                                  row_base_o <= nxt_sum[ADDR_W-1:0];
      end else begin
        rep_q <= 1'b1;
      end
    end
  end

  // R8
  vblank_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |=> (row_base_o == '0));

  // R4
  repeat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !vblank_i && !rep_q) |=> $stable(row_base_o));

  // R5
  ptr_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    row_base_o <= ADDR_W'(LAST_WORD));
endmodule

// File: rtl/ovl_pixel_shifter.sv
module ovl_pixel_shifter
  import ovl_pkg::*;
#(
  parameter int WORD_W    = 8,
  parameter int WORDS     = 4,
  parameter int START_CYC = 240,
  parameter int PIX_DIV   = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              cancel_i,
  input  logic [ADDR_W-1:0] base_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              pix_o
);
  localparam int DLY_W = (START_CYC > 1) ? $clog2(START_CYC) : 1;
  localparam int DIV_W = (PIX_DIV > 1) ? $clog2(PIX_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int WRD_W = $clog2(WORDS + 2);

  ovl_state_e        state_q;
  logic [DLY_W-1:0]  dly_q;
  logic [DIV_W-1:0]  div_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WRD_W-1:0]  wrd_q;
  logic [ADDR_W-1:0] base_q;
  logic [WORD_W-1:0] sh_q, nxt_q;
  logic              pend_q;

  logic dly_last, div_last, bit_last, wrd_last, edge_word;
  logic [ADDR_W-1:0] rd_off;

  assign dly_last  = (dly_q == DLY_W'(START_CYC - 1));
  assign div_last  = (div_q == DIV_W'(PIX_DIV - 1));
  assign bit_last  = (bit_q == BIT_W'(WORD_W - 1));
  assign wrd_last  = (wrd_q == WRD_W'(WORDS - 1));
  assign edge_word = (state_q == ST_SHIFT) && div_last && bit_last;

  always_comb begin
    rd_en_o = 1'b0;
    rd_off  = '0;
    unique case (state_q)
      ST_DELAY: rd_en_o = dly_last;
      ST_LOAD: begin
        rd_en_o = (WORDS > 1);
        rd_off  = ADDR_W'(1);
      end
      ST_SHIFT: begin
        rd_en_o = edge_word && (int'(wrd_q) + 2 < WORDS);
        rd_off  = ADDR_W'(wrd_q) + ADDR_W'(2);
      end
      default: ;
    endcase
  end

  assign rd_addr_o = base_q + rd_off;
  assign pix_o     = (state_q == ST_SHIFT) && sh_q[WORD_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dly_q   <= '0;
      div_q   <= '0;
      bit_q   <= '0;
      wrd_q   <= '0;
      base_q  <= '0;
      sh_q    <= '0;
      nxt_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      pend_q <= rd_en_o && (state_q != ST_DELAY);
      if (pend_q) nxt_q <= rd_data_i;
      if (start_i) begin
        state_q <= ST_DELAY;
        base_q  <= base_i;
        dly_q   <= '0;
      end else if (cancel_i) begin
        state_q <= ST_IDLE;
      end else begin
        unique case (state_q)
          ST_DELAY: begin
            dly_q <= dly_q + 1'b1;
            if (dly_last) state_q <= ST_LOAD;
          end
          ST_LOAD: begin
            sh_q    <= rd_data_i;
            div_q   <= '0;
            bit_q   <= '0;
            wrd_q   <= '0;
            state_q <= ST_SHIFT;
          end
          ST_SHIFT: begin
            if (div_last) begin
              div_q <= '0;
              if (bit_last) begin
                bit_q <= '0;
                if (wrd_last) state_q <= ST_IDLE;
                else begin
                  wrd_q <= wrd_q + 1'b1;
                  sh_q  <= nxt_q;
                end
              end else begin
                bit_q <= bit_q + 1'b1;
                sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
              end
            end else begin
              div_q <= div_q + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  start_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !pix_o);

  // R10
  data_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_LOAD && !start_i && !cancel_i) |-> $past(rd_en_o));
endmodule

// File: rtl/overlay_scanner.sv
module overlay_scanner #(
  parameter int LINE_W      = 10,
  parameter int FIELD_LINES = 312,
  parameter int WIN_START   = 118,
  parameter int IMG_H       = 48,
  parameter int WORDS       = 4,
  parameter int WORD_W      = 8,
  parameter int START_CYC   = 240,
  parameter int PIX_DIV     = 4,
  parameter int ADDR_W      = (IMG_H * WORDS > 1) ? $clog2(IMG_H * WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_strobe_i,
  input  logic [LINE_W-1:0] line_num_i,
  input  logic              vblank_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              pix_o
);
  localparam int IMG_WORDS = IMG_H * WORDS;

  logic              in_win;
  logic              draw_go;
  logic [ADDR_W-1:0] row_base;

  assign draw_go = line_strobe_i && in_win;

  ovl_line_window #(
    .LINE_W(LINE_W), .FIELD_LINES(FIELD_LINES), .WIN_START(WIN_START), .IMG_H(IMG_H)
  ) u_win (
    .line_num_i(line_num_i),
    .in_win_o  (in_win)
  );

  ovl_row_ptr #(.IMG_H(IMG_H), .WORDS(WORDS), .ADDR_W(ADDR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vblank_i  (vblank_i),
    .adv_i     (draw_go),
    .row_base_o(row_base)
  );

  ovl_pixel_shifter #(
    .WORD_W(WORD_W), .WORDS(WORDS), .START_CYC(START_CYC), .PIX_DIV(PIX_DIV), .ADDR_W(ADDR_W)
  ) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (draw_go),
    .cancel_i (line_strobe_i && !in_win),
    .base_i   (row_base),
    .rd_en_o  (rd_en_o),
    .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i),
    .pix_o    (pix_o)
  );

  // R2
  out_win_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_strobe_i && !in_win) |=> (!rd_en_o && !pix_o));

  // R10
  rd_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> (rd_addr_o < ADDR_W'(IMG_WORDS)));
endmodule

// File: tb/tb_overlay_scanner.sv
module tb_overlay_scanner;
  localparam int LINE_W = 10, IMG_H = 3, WORDS = 2, WORD_W = 8;
  localparam int START_CYC = 4, PIX_DIV = 2;
  localparam int ADDR_W = $clog2(IMG_H * WORDS);
  localparam int NPIX_CYC = WORDS * WORD_W * PIX_DIV;
  localparam int LINE_CYC = START_CYC + 1 + NPIX_CYC + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strobe = 1'b0, vblank = 1'b0;
  logic [LINE_W-1:0] line_num = '0;
  logic rd_en, pix;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] rd_data = '0;

  int checks = 0, errors = 0;
  int m_row = 0;
  bit m_rep = 0;

  typedef struct { logic exp; string tag; } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  overlay_scanner #(
    .LINE_W(LINE_W), .IMG_H(IMG_H), .WORDS(WORDS), .WORD_W(WORD_W),
    .START_CYC(START_CYC), .PIX_DIV(PIX_DIV)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .line_strobe_i(strobe), .line_num_i(line_num),
    .vblank_i(vblank), .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data), .pix_o(pix)
  );

  function automatic logic [WORD_W-1:0] img_word(int a);
    return WORD_W'(a * 73 + 29) ^ 8'h5A;
  endfunction

  // bitmap store: synchronous read
  always @(posedge clk) if (rd_en) rd_data <= img_word(int'(rd_addr));

  task automatic drive_line(int ln, string pix_tag);
    int f;
    bit win;
    f = (ln > 312) ? ln - 312 : ln;
    win = (f > 118) && (f < 118 + 2 * IMG_H);
    @(negedge clk);
    strobe = 1'b1;
    line_num = LINE_W'(ln);
    for (int m = 0; m < LINE_CYC; m++) begin
      item_t it;
      if (!win) begin
        it.exp = 1'b0; it.tag = "R2";
      end else if (m < START_CYC + 1) begin
        it.exp = 1'b0; it.tag = "R3";
      end else if (m >= START_CYC + 1 + NPIX_CYC) begin
        it.exp = 1'b0; it.tag = "R7";
      end else begin
        int p, w, b;
        logic [WORD_W-1:0] wd;
        p = (m - START_CYC - 1) / PIX_DIV;
        w = p / WORD_W;
        b = WORD_W - 1 - (p % WORD_W);
        wd = img_word(m_row * WORDS + w);
        it.exp = wd[b]; it.tag = pix_tag;
      end
      sb_q.push_back(it);
    end
    if (win) begin
      if (m_rep) begin
        m_rep = 0;
        m_row = (m_row + 1 >= IMG_H) ? 0 : m_row + 1;
      end else m_rep = 1;
    end
    @(negedge clk);
    strobe = 1'b0;
    repeat (LINE_CYC - 1) @(negedge clk);
  endtask

  task automatic pulse_vblank();
    @(negedge clk);
    vblank = 1'b1;
    @(negedge clk);
    vblank = 1'b0;
    m_row = 0;
    m_rep = 0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // monitor
  initial forever begin
    @(posedge clk);
    #6;
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      checks++;
      if (pix !== it.exp) begin
        errors++;
        $display("FAIL %s pix_o at %0t: actual=%b expected=%b", it.tag, $time, pix, it.exp);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    checks++;
    if (pix !== 1'b0 || rd_en !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset: actual pix=%b rd_en=%b expected 0 0", pix, rd_en);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (pix !== 1'b0 || rd_en !== 1'b0) begin
      errors++;
      $display("FAIL R9 after reset: actual pix=%b rd_en=%b expected 0 0", pix, rd_en);
    end
    // R2 window bounds, R4 doubling, R6 bit order
    drive_line(100, "R2");
    drive_line(118, "R2");
    drive_line(119, "R6");
    drive_line(120, "R4");
    drive_line(121, "R4");
    drive_line(122, "R4");
    drive_line(123, "R4");
    drive_line(124, "R2");
    drive_line(312, "R2");
    // R5 wrap: row 2 repeat, then pointer back to 0
    drive_line(119, "R5");
    drive_line(120, "R5");
    // R1 folded second field after R8 reset
    pulse_vblank();
    drive_line(431, "R1");
    drive_line(432, "R1");
    drive_line(433, "R1");
    drive_line(430, "R2");
    drive_line(436, "R2");
    // R8 vblank mid-image
    pulse_vblank();
    drive_line(121, "R8");
    drive_line(122, "R8");
    // R2 cancel: out-of-window strobe during a drawn line
    @(negedge clk);
    strobe = 1'b1; line_num = LINE_W'(119);
    @(negedge clk);
    strobe = 1'b1; line_num = LINE_W'(50);
    @(negedge clk);
    strobe = 1'b0;
    m_row = 1; m_rep = 0;
    repeat (LINE_CYC) begin
      @(negedge clk);
      checks++;
      if (pix !== 1'b0) begin
        errors++;
        $display("FAIL R2 cancel: actual pix=%b expected 0", pix);
      end
    end
    drive_line(119, "R4");
    wait (sb_q.size() == 0);
    repeat (3) @(negedge clk);
    report();
  end
endmodule